// File: doc/BRIEF.md
# Accumulator Memory Addressing Unit

This unit carries out accumulator loads, accumulator/memory swaps and single-bit operations against a small byte-wide data RAM. Each operation arrives as an already decoded operation code, an addressing-mode code, a pointer select and an operand byte. The unit resolves the effective address, performs the access and pulses `done` when the operation has finished.

There are two pointer registers, called B and X. They are mapped into the top two locations of the data space, so ordinary loads, swaps and bit operations can reach them. Indirect modes address memory through either pointer. The post-modify modes step the chosen pointer only after the access has used its old value. Immediate mode takes the operand byte itself as data.

An upstream sequencer raises `start` for one cycle with the fields valid. It then waits for `done` before it issues the next operation.

Top module: `accmem_unit`

## Requirements
- R1: A synchronous reset clears the accumulator, both pointers, `done` and `bit_valid`. The data RAM powers up at zero and is not cleared by reset.
- R2: In direct mode (mode code 0), the effective address is the operand byte. A load (op code 0) copies that location into the accumulator.
- R3: In indirect mode (mode code 1), the address is pointer B when `ptr_sel`=0 and pointer X when `ptr_sel`=1. Neither pointer changes.
- R4: Mode code 2 (post-increment) and mode code 3 (post-decrement) access the location held by the selected pointer. They then add 1 to, or subtract 1 from, that pointer modulo 256. If the same operation also writes that pointer's own location, the step takes precedence.
- R5: A swap (op code 1) writes the old accumulator into the addressed location and places the old location value in the accumulator.
- R6: In immediate mode (mode code 4), a load places the operand in the accumulator and touches neither memory nor the pointers.
- R7: Bit set (op code 2) and bit clear (op code 3) force bit `bit_idx` (0 = least significant) of the addressed location to 1 or 0. The other bits keep their values.
- R8: Bit test (op code 4) pulses `bit_valid` for exactly the cycle in which `done` is high, with `bit_result` equal to the selected bit. Memory is not changed.
- R9: Pointer B is readable and writable as data address 0xFE, and pointer X as data address 0xFF, in every mode and by every operation.
- R10: `done` is a single-cycle pulse. It appears one clock edge after an immediate start and two edges after any other start. A `start` that arrives while an operation is in progress is ignored. Without a start, the accumulator and the pointers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the fields below |
| op_code | input | 3 | 0 load, 1 swap, 2 bit set, 3 bit clear, 4 bit test |
| mode_code | input | 3 | 0 direct, 1 indirect, 2 post-increment, 3 post-decrement, 4 immediate |
| ptr_sel | input | 1 | 0 selects pointer B, 1 selects pointer X |
| operand | input | 8 | Direct address or immediate data |
| bit_idx | input | 3 | Bit position for bit operations |
| done | output | 1 | One-cycle completion pulse |
| acc | output | 8 | Accumulator |
| ptr_b | output | 8 | Pointer B |
| ptr_x | output | 8 | Pointer X |
| bit_result | output | 1 | Result of the last bit test |
| bit_valid | output | 1 | Marks the cycle in which `bit_result` is new |

## Verification
An immediate operation updates the accumulator and raises `done` on the first rising edge after `start` is sampled. Every memory operation reads on that edge and writes or loads on the second, so `done` arrives one cycle later. The bench drives on falling edges and checks `done` at each falling edge up to the expected one. It compares the accumulator, both pointers and any bit-test result at that falling edge, then checks one edge later that the pulse has ended. Memory contents are observed only through later direct loads against a bench model of the RAM, pointers and accumulator.

// File: rtl/accmem_pkg.sv
package accmem_pkg;

  typedef enum logic [2:0] {
    OP_LD   = 3'd0,
    OP_XCH  = 3'd1,
    OP_BSET = 3'd2,
    OP_BCLR = 3'd3,
    OP_BTST = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    AM_DIR  = 3'd0,
    AM_PTR  = 3'd1,
    AM_PINC = 3'd2,
    AM_PDEC = 3'd3,
    AM_IMM  = 3'd4
  } mode_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_ACT  = 1'b1
  } state_e;

  typedef struct packed {
    op_e   op;
    mode_e mode;
    logic  sel;
  } ctl_t;

endpackage

// File: rtl/accmem_addr_gen.sv
module accmem_addr_gen
  import accmem_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  mode_e              mode_in,
  input  logic               sel_in,
  input  logic [DATA_W-1:0]  operand_in,
  input  mode_e              mode_q,
  input  logic               sel_q,
  input  logic [DATA_W-1:0]  ptr_b,
  input  logic [DATA_W-1:0]  ptr_x,
  output logic [ADDR_W-1:0]  eff_addr,
  output logic               is_imm,
  output logic               step_en,
  output logic [DATA_W-1:0]  step_val
);

  logic [DATA_W-1:0] sel_ptr_in;
  logic [DATA_W-1:0] sel_ptr_q;

  assign sel_ptr_in = sel_in ? ptr_x : ptr_b;
  assign sel_ptr_q  = sel_q  ? ptr_x : ptr_b;

  always_comb begin
    is_imm   = 1'b0;
    eff_addr = sel_ptr_in[ADDR_W-1:0];
    case (mode_in)
      AM_DIR:  eff_addr = operand_in[ADDR_W-1:0];
      AM_IMM:  is_imm   = 1'b1;
      default: eff_addr = sel_ptr_in[ADDR_W-1:0];
    endcase
  end

  always_comb begin
    step_en  = 1'b0;
    step_val = sel_ptr_q;
    case (mode_q)
      AM_PINC: begin
        step_en  = 1'b1;
        step_val = sel_ptr_q + DATA_W'(1);
      end
      AM_PDEC: begin
        step_en  = 1'b1;
        step_val = sel_ptr_q - DATA_W'(1);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/accmem_ram.sv
module accmem_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/accmem_bitops.sv
module accmem_bitops #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] val_set,
  output logic [DATA_W-1:0] val_clr,
  output logic              bit_at
);

  logic [DATA_W-1:0] mask;

  assign mask    = DATA_W'(1) << idx;
  assign val_set = val | mask;
  assign val_clr = val & ~mask;
  assign bit_at  = |(val & mask);

endmodule

// File: rtl/accmem_unit.sv
module accmem_unit
  import accmem_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op_code,
  input  logic [2:0]        mode_code,
  input  logic              ptr_sel,
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic              done,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] ptr_b,
  output logic [DATA_W-1:0] ptr_x,
  output logic              bit_result,
  output logic              bit_valid
);

  localparam logic [ADDR_W-1:0] B_LOC = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] X_LOC = {ADDR_W{1'b1}};

  state_e            st;
  ctl_t              ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;

  op_e               op_in;
  mode_e             mode_in;
  logic [ADDR_W-1:0] eff_addr;
  logic              is_imm;
  logic              step_en;
  logic [DATA_W-1:0] step_val;

  logic [DATA_W-1:0] ram_rdata;
  logic              ram_we;
  logic [DATA_W-1:0] wr_val;
  logic              wr_en;
  logic              map_b;
  logic              map_x;
  logic [DATA_W-1:0] cur_val;
  logic [DATA_W-1:0] val_set;
  logic [DATA_W-1:0] val_clr;
  logic              bit_at;
  logic              act;
  logic              accept;

  assign op_in   = op_e'(op_code);
  assign mode_in = mode_e'(mode_code);
  assign act     = (st == S_ACT);
  assign accept  = (st == S_IDLE) && start;

  accmem_addr_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
    .mode_in   (mode_in),
    .sel_in    (ptr_sel),
    .operand_in(operand),
    .mode_q    (ctl_q.mode),
    .sel_q     (ctl_q.sel),
    .ptr_b     (ptr_b),
    .ptr_x     (ptr_x),
    .eff_addr  (eff_addr),
    .is_imm    (is_imm),
    .step_en   (step_en),
    .step_val  (step_val)
  );

  accmem_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk  (clk),
    .raddr(eff_addr),
    .rdata(ram_rdata),
    .we   (ram_we),
    .waddr(addr_q),
    .wdata(wr_val)
  );

  assign map_b   = (addr_q == B_LOC);
  assign map_x   = (addr_q == X_LOC);
  assign cur_val = map_b ? ptr_b : (map_x ? ptr_x : ram_rdata);

  accmem_bitops #(.DATA_W(DATA_W)) u_bits (
    .val    (cur_val),
    .idx    (idx_q),
    .val_set(val_set),
    .val_clr(val_clr),
    .bit_at (bit_at)
  );

  always_comb begin
    wr_en  = 1'b0;
    wr_val = cur_val;
    if (act) begin
      case (ctl_q.op)
        OP_XCH:  begin wr_en = 1'b1; wr_val = acc;     end
        OP_BSET: begin wr_en = 1'b1; wr_val = val_set; end
        OP_BCLR: begin wr_en = 1'b1; wr_val = val_clr; end
        default: ;
      endcase
    end
  end

  assign ram_we = wr_en && !map_b && !map_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      ctl_q  <= '0;
      addr_q <= '0;
      idx_q  <= '0;
    end else if (accept) begin
      ctl_q  <= '{op: op_in, mode: mode_in, sel: ptr_sel};
      addr_q <= eff_addr;
      idx_q  <= bit_idx;
      st     <= is_imm ? S_IDLE : S_ACT;
    end else if (act) begin
      st <= S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (accept && is_imm && op_in == OP_LD) begin
      acc <= operand;
    end else if (act && (ctl_q.op == OP_LD || ctl_q.op == OP_XCH)) begin
      acc <= cur_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_b <= '0;
    end else if (act) begin
      if (step_en && !ctl_q.sel) ptr_b <= step_val;
      else if (wr_en && map_b)   ptr_b <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_x <= '0;
    end else if (act) begin
      if (step_en && ctl_q.sel) ptr_x <= step_val;
      else if (wr_en && map_x)  ptr_x <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      bit_valid  <= 1'b0;
      bit_result <= 1'b0;
    end else begin
      done      <= (accept && is_imm) || act;
      bit_valid <= act && (ctl_q.op == OP_BTST);
      if (act && ctl_q.op == OP_BTST) bit_result <= bit_at;
    end
  end

  AST_ACT_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
    act |=> done); // R10

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !start) |=> ($stable(acc) && $stable(ptr_b) && $stable(ptr_x))); // R10

  AST_IMM_LOADS_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (accept && mode_in == AM_IMM && op_in == OP_LD) |=> (acc == $past(operand) && done)); // R6

  AST_IMM_KEEPS_POINTERS: assert property (@(posedge clk) disable iff (rst)
    (accept && mode_in == AM_IMM) |=> ($stable(ptr_b) && $stable(ptr_x))); // R6

  AST_POSTINC_B: assert property (@(posedge clk) disable iff (rst)
    (act && ctl_q.mode == AM_PINC && !ctl_q.sel) |=> (ptr_b == DATA_W'($past(ptr_b) + DATA_W'(1)))); // R4

  AST_POSTDEC_X: assert property (@(posedge clk) disable iff (rst)
    (act && ctl_q.mode == AM_PDEC && ctl_q.sel) |=> (ptr_x == DATA_W'($past(ptr_x) - DATA_W'(1)))); // R4

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (act && ctl_q.op == OP_BTST) |-> !ram_we); // R8

  AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> done); // R8

endmodule

// File: tb/tb_accmem_unit.sv
module tb_accmem_unit;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [2:0] op_code;
  logic [2:0] mode_code;
  logic       ptr_sel;
  logic [7:0] operand;
  logic [2:0] bit_idx;
  logic       done;
  logic [7:0] acc;
  logic [7:0] ptr_b;
  logic [7:0] ptr_x;
  logic       bit_result;
  logic       bit_valid;

  always #5 clk = ~clk;

  accmem_unit dut (
    .clk(clk), .rst(rst), .start(start), .op_code(op_code), .mode_code(mode_code),
    .ptr_sel(ptr_sel), .operand(operand), .bit_idx(bit_idx), .done(done), .acc(acc),
    .ptr_b(ptr_b), .ptr_x(ptr_x), .bit_result(bit_result), .bit_valid(bit_valid)
  );

  int total = 0;
  int bad   = 0;

  logic [7:0] rm [256];
  logic [7:0] ra, rb, rx;
  logic       rbit;

  task automatic chk(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic mwrite(input logic [7:0] a, input logic [7:0] v);
    if (a == 8'hFE) rb = v;
    else if (a == 8'hFF) rx = v;
    else rm[a] = v;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [2:0] m, input logic s,
                        input logic [7:0] opd, input logic [2:0] bi, input string tag,
                        input bit hold = 1'b0);
    logic [7:0] ea;
    logic [7:0] old;
    logic [7:0] prev_acc;
    int lat;
    lat = (m == 3'd4) ? 1 : 2;
    ea  = (m == 3'd0) ? opd : (s ? rx : rb);
    if (m == 3'd4) begin
      if (o == 3'd0) ra = opd;
    end else begin
      old = (ea == 8'hFE) ? rb : ((ea == 8'hFF) ? rx : rm[ea]);
      case (o)
        3'd0: ra = old;
        3'd1: begin prev_acc = ra; ra = old; mwrite(ea, prev_acc); end
        3'd2: mwrite(ea, old | (8'd1 << bi));
        3'd3: mwrite(ea, old & ~(8'd1 << bi));
        3'd4: rbit = old[bi];
        default: ;
      endcase
      if (m == 3'd2) begin if (s) rx = rx + 8'd1; else rb = rb + 8'd1; end
      if (m == 3'd3) begin if (s) rx = rx - 8'd1; else rb = rb - 8'd1; end
    end
    @(negedge clk);
    start = 1'b1; op_code = o; mode_code = m; ptr_sel = s; operand = opd; bit_idx = bi;
    @(negedge clk);
    if (!hold) start = 1'b0;
    if (lat == 2) begin
      chk({tag, " R10 done not early"}, {7'd0, done}, 8'd0);
      @(negedge clk);
      start = 1'b0;
    end
    chk({tag, " R10 done due"}, {7'd0, done}, 8'd1);
    chk({tag, " acc"}, acc, ra);
    chk({tag, " ptr_b"}, ptr_b, rb);
    chk({tag, " ptr_x"}, ptr_x, rx);
    if (o == 3'd4 && m != 3'd4) begin
      chk({tag, " R8 valid"}, {7'd0, bit_valid}, 8'd1);
      chk({tag, " R8 result"}, {7'd0, bit_result}, {7'd0, rbit});
    end
    @(negedge clk);
    chk({tag, " R10 single pulse"}, {7'd0, done}, 8'd0);
    chk({tag, " R8 valid drops"}, {7'd0, bit_valid}, 8'd0);
  endtask

  task automatic set_ptr(input logic [7:0] loc, input logic [7:0] v);
    run_op(3'd0, 3'd4, 1'b0, v, 3'd0, "R6 imm");
    run_op(3'd1, 3'd0, 1'b0, loc, 3'd0, "R9 write ptr");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) rm[i] = 8'h00;
    ra = 8'h00; rb = 8'h00; rx = 8'h00; rbit = 1'b0;
    rst = 1'b1; start = 1'b0; op_code = '0; mode_code = '0; ptr_sel = 1'b0;
    operand = '0; bit_idx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 acc", acc, 8'h00);
    chk("R1 ptr_b", ptr_b, 8'h00);
    chk("R1 ptr_x", ptr_x, 8'h00);
    chk("R1 done", {7'd0, done}, 8'd0);
    chk("R1 bit_valid", {7'd0, bit_valid}, 8'd0);

    // R5 R2: fill every plain location by swapping in an immediate value
    for (int a = 0; a < 254; a++) begin
      run_op(3'd0, 3'd4, 1'b0, 8'((a * 37 + 11) & 255), 3'd0, "R6 fill imm");
      run_op(3'd1, 3'd0, 1'b0, 8'(a), 3'd0, "R5 fill swap");
    end
    // R2: read back every location with direct loads
    for (int a = 0; a < 254; a++) run_op(3'd0, 3'd0, 1'b0, 8'(a), 3'd0, "R2 direct load");

    // R9: pointers through their data addresses
    set_ptr(8'hFE, 8'h10);
    set_ptr(8'hFF, 8'hF0);
    run_op(3'd0, 3'd0, 1'b0, 8'hFE, 3'd0, "R9 read B");
    run_op(3'd0, 3'd0, 1'b0, 8'hFF, 3'd0, "R9 read X");

    // R3: plain indirect through each pointer
    run_op(3'd0, 3'd1, 1'b0, 8'h00, 3'd0, "R3 load via B");
    run_op(3'd1, 3'd1, 1'b1, 8'h00, 3'd0, "R3 R5 swap via X");
    run_op(3'd0, 3'd0, 1'b0, 8'hF0, 3'd0, "R3 verify X target");

    // R4: walks
    for (int i = 0; i < 8; i++) run_op(3'd0, 3'd2, 1'b0, 8'h00, 3'd0, "R4 post-inc B");
    for (int i = 0; i < 8; i++) run_op(3'd0, 3'd3, 1'b1, 8'h00, 3'd0, "R4 post-dec X");
    set_ptr(8'hFE, 8'hFF);
    run_op(3'd0, 3'd2, 1'b0, 8'h00, 3'd0, "R4 R9 inc wrap");
    run_op(3'd0, 3'd3, 1'b0, 8'h00, 3'd0, "R4 dec wrap");

    // R5: swap example and swap through B with post-increment
    run_op(3'd0, 3'd4, 1'b0, 8'h87, 3'd0, "R6 imm");
    run_op(3'd1, 3'd0, 1'b0, 8'h05, 3'd0, "R5 preload");
    run_op(3'd0, 3'd4, 1'b0, 8'h01, 3'd0, "R6 imm");
    run_op(3'd1, 3'd0, 1'b0, 8'h05, 3'd0, "R5 swap example");
    chk("R5 acc example", acc, 8'h87);
    run_op(3'd0, 3'd0, 1'b0, 8'h05, 3'd0, "R5 mem example");
    chk("R5 mem example value", acc, 8'h01);
    set_ptr(8'hFE, 8'h05);
    run_op(3'd1, 3'd2, 1'b0, 8'h00, 3'd0, "R4 R5 swap post-inc");
    chk("R4 B after swap", ptr_b, 8'h06);

    // R6: immediate leaves memory alone
    run_op(3'd0, 3'd4, 1'b0, 8'h22, 3'd0, "R6 imm no access");
    run_op(3'd0, 3'd0, 1'b0, 8'h22, 3'd0, "R6 memory untouched");

    // R7 R8: bit sweeps on plain locations and on pointer X
    foreach (rm[k]) if (k == 8'h22 || k == 8'h80) begin
      for (int b = 0; b < 8; b++) begin
        run_op(3'd2, 3'd0, 1'b0, 8'(k), 3'(b), "R7 set");
        run_op(3'd4, 3'd0, 1'b0, 8'(k), 3'(b), "R8 test set");
        run_op(3'd3, 3'd0, 1'b0, 8'(k), 3'(b), "R7 clear");
        run_op(3'd4, 3'd0, 1'b0, 8'(k), 3'(b), "R8 test clear");
        run_op(3'd0, 3'd0, 1'b0, 8'(k), 3'd0, "R7 readback");
      end
    end
    for (int b = 0; b < 8; b += 3) begin
      run_op(3'd2, 3'd0, 1'b0, 8'hFF, 3'(b), "R7 R9 set on X");
      run_op(3'd4, 3'd1, 1'b0, 8'h00, 3'(b), "R8 test via B");
    end
    run_op(3'd3, 3'd1, 1'b1, 8'h00, 3'd1, "R7 clear via X");
    run_op(3'd4, 3'd2, 1'b1, 8'h00, 3'd1, "R8 R4 test post-inc X");

    // R10: start held during the active cycle must not start a second swap
    run_op(3'd0, 3'd4, 1'b0, 8'h5A, 3'd0, "R6 imm");
    run_op(3'd1, 3'd0, 1'b0, 8'h30, 3'd0, "R10 held start", 1'b1);
    run_op(3'd0, 3'd0, 1'b0, 8'h30, 3'd0, "R10 single swap");
    chk("R10 held start value", acc, 8'h5A);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule